// File: doc/BRIEF.md
# Sensor Fault Supervisor

This block is the digital fault watchdog of a sensor interface. It watches three fault sources and holds any fault in a sticky latch. The first source is a low-supply flag. The second is a monitored oscillator that may run too slowly or stop. The third is a bank of trim-memory bits whose parity must stay even. A single status pin reports the latch. The status pin is also forced high whenever the self-test pin is high, so a board test can confirm that both pins are wired.

The latch can only be cleared by a self-test pulse that stays high for a minimum time, and only when no fault source is still active. After reset the latch content is not trusted: the status pin shows nothing until the first rising edge on self-test. That edge loads the latch with the faults present at that moment. The self-test, low-supply and monitored-clock inputs are asynchronous and are synchronised to the reference clock inside the block.

Top module: `sensor_fault_supervisor`

## Requirements
- R1: `status_out` is 1 in every cycle in which `selftest_in` is 1, whatever the state of the latch and of the valid flag.
- R2: After reset and before the first rising edge of `selftest_in`, `status_out` is 0 while `selftest_in` is 0, even if a fault has occurred.
- R3: The first synchronised rising edge of `selftest_in` after reset sets the valid flag. On that edge the latch is loaded with 1 if a fault is present, else with 0. The valid flag then stays set until reset.
- R4: The trim check XORs together all `TRIM_W` bits of `trim_bits`. A result of 1 (odd number of ones) is a fault; a result of 0 is not.
- R5: `lowv_in` counts as a fault only after its synchronised value has been 1 for `LV_HOLD` consecutive reference cycles. A shorter high pulse has no effect on `status_out`.
- R6: The reference clock is divided into windows of `WIN_CYCLES` cycles. A window that sees fewer than `MIN_EDGES` synchronised rising edges of `mon_clk_in` is a fault; zero edges is a fault. A window with exactly `MIN_EDGES` edges is not.
- R7: Once set, the latch stays at 1 after every fault source has gone away, until a valid clear.
- R8: A clear request is issued once per self-test pulse, when the synchronised `selftest_in` has been high for `QUAL_CYCLES` cycles. A shorter pulse leaves the latch unchanged.
- R9: A clear request made while any fault source is active is ignored, and the latch stays at 1.
- R10: Synchronous active-high `rst` clears the latch, the valid flag and all counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| selftest_in | input | 1 | Self-test pin (asynchronous) |
| lowv_in | input | 1 | Low-supply detect flag (asynchronous) |
| mon_clk_in | input | 1 | Monitored oscillator (asynchronous) |
| trim_bits | input | TRIM_W | Trim-memory bits checked for parity |
| status_out | output | 1 | Fault status, ORed with self-test |

## Verification
The bench builds the block with these parameters:

- `TRIM_W=8`
- `WIN_CYCLES=64`
- `MIN_EDGES=4`
- `QUAL_CYCLES=20`
- `LV_HOLD=3`

The short monitor window makes each clock case reachable in a few hundred cycles: a healthy oscillator, one giving exactly `MIN_EDGES` edges per window, a slightly slower one, and a stopped one. The short qualification time lets the bench place self-test pulses on either side of the clear threshold. The three-cycle hold lets a two-cycle glitch on the supply flag be rejected while a sustained level is latched.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

    // One bit per supervised fault source.
    typedef struct packed {
        logic lowv;
        logic slow_clk;
        logic parity;
    } fault_vec_t;

    function automatic logic fault_any(input fault_vec_t f);
        return |f;
    endfunction

    // Width of a counter that must reach the value n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sfl_sync.sv
module sfl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES < 2) begin : g_single
            logic ff;
            always_ff @(posedge clk) begin
                if (rst) ff <= 1'b0;
                else     ff <= d;
            end
            assign q = ff;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], d};
            end
            assign q = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sfl_lv_filter.sv
module sfl_lv_filter #(
    parameter int unsigned HOLD   = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lv_async,
    output logic fault
);
    import sfl_pkg::*;
    localparam int unsigned CW = cnt_width(HOLD);

    logic          lv_s;
    logic [CW-1:0] run_cnt;

    sfl_sync #(.STAGES(STAGES)) u_sync (.clk(clk), .rst(rst), .d(lv_async), .q(lv_s));

    always_ff @(posedge clk) begin
        if (rst || !lv_s)            run_cnt <= '0;
        else if (run_cnt != CW'(HOLD)) run_cnt <= run_cnt + 1'b1;
    end

    assign fault = (run_cnt == CW'(HOLD));

    AST_LV_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> $past(lv_s)); // R5
endmodule

// File: rtl/sfl_clk_monitor.sv
module sfl_clk_monitor #(
    parameter int unsigned WIN_CYCLES = 25000,
    parameter int unsigned MIN_EDGES  = 10,
    parameter int unsigned STAGES     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mon_clk,
    output logic fault
);
    import sfl_pkg::*;
    localparam int unsigned WW = cnt_width(WIN_CYCLES - 1);
    localparam int unsigned EW = cnt_width(MIN_EDGES);

    logic          mon_s, mon_d, mon_rise;
    logic [WW-1:0] win_cnt;
    logic [EW-1:0] edge_cnt, edge_next;
    logic          win_end;

    sfl_sync #(.STAGES(STAGES)) u_sync (.clk(clk), .rst(rst), .d(mon_clk), .q(mon_s));

    assign mon_rise  = mon_s & ~mon_d;
    assign win_end   = (win_cnt == WW'(WIN_CYCLES - 1));
    assign edge_next = (mon_rise && edge_cnt != EW'(MIN_EDGES)) ? edge_cnt + 1'b1 : edge_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_d    <= 1'b0;
            win_cnt  <= '0;
            edge_cnt <= '0;
            fault    <= 1'b0;
        end else begin
            mon_d <= mon_s;
            if (win_end) begin
                win_cnt  <= '0;
                edge_cnt <= '0;
                fault    <= (edge_next < EW'(MIN_EDGES));
            end else begin
                win_cnt  <= win_cnt + 1'b1;
                edge_cnt <= edge_next;
            end
        end
    end

    AST_VERDICT_AT_WINDOW_END: assert property (@(posedge clk) disable iff (rst)
        (fault != $past(fault)) |-> ($past(win_cnt) == WW'(WIN_CYCLES - 1))); // R6
endmodule

// File: rtl/sfl_st_qual.sv
module sfl_st_qual #(
    parameter int unsigned QUAL_CYCLES = 12500,
    parameter int unsigned STAGES      = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic st_async,
    output logic rise,
    output logic clear_req
);
    import sfl_pkg::*;
    localparam int unsigned QW = cnt_width(QUAL_CYCLES);

    logic          st_s, st_d;
    logic [QW-1:0] hi_cnt;

    sfl_sync #(.STAGES(STAGES)) u_sync (.clk(clk), .rst(rst), .d(st_async), .q(st_s));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_d   <= 1'b0;
            hi_cnt <= '0;
        end else begin
            st_d <= st_s;
            if (!st_s)                         hi_cnt <= '0;
            else if (hi_cnt != QW'(QUAL_CYCLES)) hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assign rise      = st_s & ~st_d;
    assign clear_req = st_s && (hi_cnt == QW'(QUAL_CYCLES - 1));

    AST_ONE_CLEAR_PER_PULSE: assert property (@(posedge clk) disable iff (rst)
        clear_req |=> !clear_req); // R8
endmodule

// File: rtl/sfl_fault_latch.sv
module sfl_fault_latch (
    input  logic                clk,
    input  logic                rst,
    input  sfl_pkg::fault_vec_t faults,
    input  logic                st_rise,
    input  logic                clear_req,
    output logic                latch_q,
    output logic                valid_q
);
    import sfl_pkg::*;

    logic active;
    assign active = fault_any(faults);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            if (st_rise) valid_q <= 1'b1;
            if (active)
                latch_q <= 1'b1;
            else if ((clear_req && valid_q) || (st_rise && !valid_q))
                latch_q <= 1'b0;
        end
    end

    AST_VALID_STAYS: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> valid_q); // R3
    AST_FAULT_SETS_LATCH: assert property (@(posedge clk) disable iff (rst)
        active |=> latch_q); // R7
    AST_NO_CLEAR_UNDER_FAULT: assert property (@(posedge clk) disable iff (rst)
        $fell(latch_q) |-> $past(!active)); // R9
    AST_CLEAR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(latch_q) |-> $past(clear_req || st_rise)); // R8
endmodule

// File: rtl/sensor_fault_supervisor.sv
module sensor_fault_supervisor #(
    parameter int unsigned TRIM_W      = 32,
    parameter int unsigned WIN_CYCLES  = 25000,
    parameter int unsigned MIN_EDGES   = 10,
    parameter int unsigned QUAL_CYCLES = 12500,
    parameter int unsigned LV_HOLD     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              selftest_in,
    input  logic              lowv_in,
    input  logic              mon_clk_in,
    input  logic [TRIM_W-1:0] trim_bits,
    output logic              status_out
);
    import sfl_pkg::*;

    fault_vec_t faults;
    logic       parity_q, st_rise, clear_req, latch_q, valid_q;

    always_ff @(posedge clk) begin
        if (rst) parity_q <= 1'b0;
        else     parity_q <= ^trim_bits;
    end
    assign faults.parity = parity_q;

    sfl_lv_filter #(.HOLD(LV_HOLD), .STAGES(SYNC_STAGES)) u_lv (
        .clk(clk), .rst(rst), .lv_async(lowv_in), .fault(faults.lowv));

    sfl_clk_monitor #(.WIN_CYCLES(WIN_CYCLES), .MIN_EDGES(MIN_EDGES), .STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst(rst), .mon_clk(mon_clk_in), .fault(faults.slow_clk));

    sfl_st_qual #(.QUAL_CYCLES(QUAL_CYCLES), .STAGES(SYNC_STAGES)) u_st (
        .clk(clk), .rst(rst), .st_async(selftest_in), .rise(st_rise), .clear_req(clear_req));

    sfl_fault_latch u_latch (
        .clk(clk), .rst(rst), .faults(faults), .st_rise(st_rise),
        .clear_req(clear_req), .latch_q(latch_q), .valid_q(valid_q));

    assign status_out = selftest_in | (valid_q & latch_q);

    AST_HIDDEN_UNTIL_VALID: assert property (@(posedge clk) disable iff (rst)
        (!valid_q && !selftest_in) |-> !status_out); // R2
    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (!valid_q && !latch_q)); // R10
endmodule

// File: tb/sim_sensor_fault_supervisor.sv
module sim_sensor_fault_supervisor;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       st = 1'b0, lv = 1'b0, mon = 1'b0;
    logic [7:0] trim = 8'h00;
    logic [5:0] mon_half = 6'd4;
    logic       status;
    int         nchk = 0, nfail = 0;

    always #4 clk = ~clk;   // 125 MHz

    sensor_fault_supervisor #(
        .TRIM_W(8), .WIN_CYCLES(64), .MIN_EDGES(4),
        .QUAL_CYCLES(20), .LV_HOLD(3), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst(rst), .selftest_in(st), .lowv_in(lv),
        .mon_clk_in(mon), .trim_bits(trim), .status_out(status));

    // Monitored oscillator: half period in reference cycles, 0 = stopped.
    initial begin
        int mcnt = 0;
        forever begin
            @(negedge clk);
            if (mon_half == 6'd0) begin
                mon = 1'b0; mcnt = 0;
            end else if (mcnt >= int'(mon_half) - 1) begin
                mon = ~mon; mcnt = 0;
            end else mcnt++;
        end
    end

    typedef struct packed {
        logic        st;
        logic        lv;
        logic [7:0]  trim;
        logic [5:0]  half;
        logic [11:0] wait_c;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,8'h01,6'd4, 12'd200,1'b0,4'd2},  // R2 odd trim hidden before valid
        '{1'b1,1'b0,8'h01,6'd4, 12'd5,  1'b1,4'd1},  // R1
        '{1'b0,1'b0,8'h01,6'd4, 12'd200,1'b1,4'd3},  // R3 first edge loads fault
        '{1'b0,1'b0,8'h00,6'd4, 12'd200,1'b1,4'd7},  // R7 sticky
        '{1'b1,1'b0,8'h00,6'd4, 12'd5,  1'b1,4'd1},  // R1 short pulse
        '{1'b0,1'b0,8'h00,6'd4, 12'd60, 1'b1,4'd8},  // R8 short pulse no clear
        '{1'b1,1'b0,8'h00,6'd4, 12'd40, 1'b1,4'd1},  // R1 long pulse
        '{1'b0,1'b0,8'h00,6'd4, 12'd10, 1'b0,4'd8},  // R8 qualified clear
        '{1'b0,1'b1,8'h00,6'd4, 12'd2,  1'b0,4'd5},  // R5 glitch
        '{1'b0,1'b0,8'h00,6'd4, 12'd60, 1'b0,4'd5},  // R5 glitch rejected
        '{1'b0,1'b1,8'h00,6'd4, 12'd20, 1'b1,4'd5},  // R5 held low supply
        '{1'b1,1'b1,8'h00,6'd4, 12'd40, 1'b1,4'd1},  // R1
        '{1'b0,1'b1,8'h00,6'd4, 12'd10, 1'b1,4'd9},  // R9 clear refused
        '{1'b0,1'b0,8'h00,6'd4, 12'd20, 1'b1,4'd7},  // R7
        '{1'b1,1'b0,8'h00,6'd4, 12'd40, 1'b1,4'd1},  // R1
        '{1'b0,1'b0,8'h00,6'd4, 12'd10, 1'b0,4'd8},  // R8
        '{1'b0,1'b0,8'h00,6'd8, 12'd300,1'b0,4'd6},  // R6 exactly MIN edges
        '{1'b0,1'b0,8'h00,6'd10,12'd400,1'b1,4'd6},  // R6 slow clock
        '{1'b0,1'b0,8'h00,6'd4, 12'd200,1'b1,4'd7},  // R7
        '{1'b1,1'b0,8'h00,6'd4, 12'd40, 1'b1,4'd1},  // R1
        '{1'b0,1'b0,8'h00,6'd4, 12'd10, 1'b0,4'd8},  // R8
        '{1'b0,1'b0,8'h00,6'd0, 12'd300,1'b1,4'd6},  // R6 stopped clock
        '{1'b0,1'b0,8'h00,6'd4, 12'd200,1'b1,4'd7},  // R7
        '{1'b1,1'b0,8'h00,6'd4, 12'd40, 1'b1,4'd1},  // R1
        '{1'b0,1'b0,8'h00,6'd4, 12'd10, 1'b0,4'd8},  // R8
        '{1'b0,1'b0,8'h03,6'd4, 12'd100,1'b0,4'd4},  // R4 even parity
        '{1'b0,1'b0,8'h07,6'd4, 12'd10, 1'b1,4'd4},  // R4 odd parity
        '{1'b1,1'b0,8'h07,6'd4, 12'd40, 1'b1,4'd1},  // R1
        '{1'b0,1'b0,8'h07,6'd4, 12'd10, 1'b1,4'd9},  // R9 parity still odd
        '{1'b0,1'b0,8'h00,6'd4, 12'd10, 1'b1,4'd7},  // R7
        '{1'b1,1'b0,8'h00,6'd4, 12'd40, 1'b1,4'd1},  // R1
        '{1'b0,1'b0,8'h00,6'd4, 12'd10, 1'b0,4'd8}   // R8
    };

    task automatic chk(input logic exp, input int req, input string what);
        nchk++;
        if (status !== exp) begin
            nfail++;
            $display("FAIL R%0d %s: status_out=%b expected %b", req, what, status, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R0 watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        cycles(5);
        rst = 1'b0;
        cycles(1);
        chk(1'b0, 10, "reset state");                 // R10

        for (int i = 0; i < NV; i++) begin
            st = TBL[i].st; lv = TBL[i].lv; trim = TBL[i].trim; mon_half = TBL[i].half;
            cycles(int'(TBL[i].wait_c));
            chk(TBL[i].exp, int'(TBL[i].req), $sformatf("vector %0d", i));
        end

        // R10: set the latch, then reset clears latch and valid flag.
        trim = 8'h01; cycles(10);
        chk(1'b1, 4, "odd trim before reset");        // R4
        rst = 1'b1; trim = 8'h00; cycles(3);
        rst = 1'b0; cycles(2);
        chk(1'b0, 10, "after reset");                 // R10
        // R2: fault after reset stays hidden (valid flag cleared by reset).
        trim = 8'h80; cycles(10);
        chk(1'b0, 2, "fault hidden after reset");     // R2
        trim = 8'h00; cycles(10);
        st = 1'b1; #1;
        chk(1'b1, 1, "self-test high while invalid"); // R1
        cycles(5);
        st = 1'b0; cycles(10);
        // R3: first edge with no fault loads 0 despite earlier hidden fault.
        chk(1'b0, 3, "first edge loads clean state"); // R3
        trim = 8'hFE; cycles(10);
        chk(1'b1, 4, "seven ones is odd");            // R4
        summary();
    end
endmodule